// File: doc/BRIEF.md
# PHY-Side Bus Grant and Data-Prefix Controller

This block sits on the physical-layer side of a link-to-PHY transmit handshake. When the link layer asks for the serial bus, the controller requests arbitration and waits for a win indication. It then fills the serial bus with a data-prefix for a minimum number of clocks. After that it grants the link-facing control pins with a transmit code, then an idle code, and releases those pins so the link can drive them.

While the link owns the control pins, link hold keeps the data-prefix on the serial side, and link transmit means packet data is flowing. If the link asks for hold after a packet, the controller takes the pins back, waits a fixed gap and grants them again for a chained packet. If the link drives idle, the controller drives its own idle and returns to rest.

When the node is root and sends isochronous data, arbitration is skipped. In that case the data-prefix is stretched so that slow receivers can lock onto the packet header. A request that arrives while a transmission is in progress is held and served once the controller is idle again.

Top module: `phy_grant_ctrl`

## Requirements
- R1: After reset the controller drives CTL to 00 and D to 0000 with both output enables high, and arb_req_o, prefix_o and data_on_o are low.
- R2: A link request with root_iso_i low raises arb_req_o from the next cycle, and it stays high until arb_won_i is seen.
- R3: A grant drives CTL=11 for exactly one cycle, then CTL=00 for one cycle, then drops ctl_oe_o and d_oe_o.
- R4: After an arbitration win, prefix_o is high for PFX_NORM cycles (default 4) before the grant code appears.
- R5: While the link owns CTL and drives hold (link code 01), prefix_o is high and the controller does not drive CTL.
- R6: While the link owns CTL and drives transmit (link code 10), data_on_o is high and prefix_o is low.
- R7: Link hold after packet data makes the controller drive CTL=00 from the next cycle, with prefix_o high for GAP_LEN cycles (default 4), followed by the R3 grant sequence.
- R8: Link idle (link code 00) while the link owns CTL makes the controller drive CTL=00 from the next cycle and return to rest with arb_req_o low.
- R9: A request with root_iso_i high never raises arb_req_o, and prefix_o is high for PFX_EXT cycles (default 16) before the grant code.
- R10: A link request pulse that arrives while a transfer is in progress is kept, and arb_req_o rises in the cycle after the controller returns to rest.
- R11: Whenever ctl_oe_o is high, d_oe_o is high and d_o is 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lreq_i | input | 1 | Link bus request pulse |
| root_iso_i | input | 1 | Node is root and sending isochronous data; skip arbitration |
| arb_won_i | input | 1 | Arbitration won indication |
| arb_req_o | output | 1 | Request to the arbitration logic |
| link_ctl_i | input | 2 | CTL value driven by the link (00 idle, 01 hold, 10 transmit) |
| ctl_o | output | 2 | CTL value driven by the PHY (00 idle, 11 transmit/grant) |
| ctl_oe_o | output | 1 | Output enable for CTL |
| d_o | output | 4 | Data value driven by the PHY |
| d_oe_o | output | 1 | Output enable for D |
| prefix_o | output | 1 | Serial bus carries data-prefix |
| data_on_o | output | 1 | Serial bus carries link packet data |

## Verification
The grant path is tried in three forms, and each one isolates a different timer load. The first is an arbitrated request, which should give a 4-cycle prefix. The second is a root isochronous request, which should give a 16-cycle prefix with no arbitration request. The third is a chained packet, which should give a 4-cycle gap. Link phases with hold before data, hold after data and idle separate the chaining decision from the release decision. A request pulse placed inside a data phase shows whether it is queued or dropped.

// File: rtl/phy_grant_pkg.sv
package phy_grant_pkg;
  typedef enum logic [2:0] {
    ST_REST  = 3'd0,
    ST_ARB   = 3'd1,
    ST_PFX   = 3'd2,
    ST_GRANT = 3'd3,
    ST_GIDLE = 3'd4,
    ST_LINK  = 3'd5,
    ST_GAP   = 3'd6
  } state_t;

  localparam logic [1:0] LNK_IDLE  = 2'b00;
  localparam logic [1:0] LNK_HOLD  = 2'b01;
  localparam logic [1:0] LNK_XMIT  = 2'b10;
  localparam logic [1:0] PHY_IDLE  = 2'b00;
  localparam logic [1:0] PHY_GRANT = 2'b11;
endpackage

// File: rtl/pgc_rst_sync.sv
module pgc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/pgc_timer.sv
module pgc_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pgc_fsm.sv
module pgc_fsm
  import phy_grant_pkg::*;
#(
  parameter int PFX_NORM = 4,
  parameter int PFX_EXT  = 16,
  parameter int GAP_LEN  = 4,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lreq_i,
  input  logic          root_iso_i,
  input  logic          arb_won_i,
  input  logic [1:0]    link_ctl_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output state_t        state_o,
  output logic          arb_req_o
);
  state_t state_q, state_d;
  logic   pend_q, pend_d;
  logic   seen_q, seen_d;
  logic   start;

  assign start = lreq_i || pend_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    case (state_q)
      ST_REST: if (start) begin
        if (root_iso_i) begin
          state_d    = ST_PFX;
          tmr_load_o = 1'b1;
          tmr_val_o  = CW'(PFX_EXT - 1);
        end else begin
          state_d = ST_ARB;
        end
      end
      ST_ARB: if (arb_won_i) begin
        state_d    = ST_PFX;
        tmr_load_o = 1'b1;
        tmr_val_o  = CW'(PFX_NORM - 1);
      end
      ST_PFX:   if (tmr_zero_i) state_d = ST_GRANT;
      ST_GRANT: state_d = ST_GIDLE;
      ST_GIDLE: state_d = ST_LINK;
      ST_LINK: begin
        if (link_ctl_i == LNK_IDLE) begin
          state_d = ST_REST;
        end else if (link_ctl_i == LNK_HOLD && seen_q) begin
          state_d    = ST_GAP;
          tmr_load_o = 1'b1;
          tmr_val_o  = CW'(GAP_LEN - 1);
        end
      end
      ST_GAP:   if (tmr_zero_i) state_d = ST_GRANT;
      default:  state_d = ST_REST;
    endcase
  end

  // request queue and data-seen flag
  always_comb begin
    pend_d = pend_q;
    if (state_q == ST_REST) begin
      if (start) pend_d = 1'b0;
    end else if (lreq_i) begin
      pend_d = 1'b1;
    end
    seen_d = seen_q;
    if (state_q == ST_GIDLE)
      seen_d = 1'b0;
    else if (state_q == ST_LINK && link_ctl_i == LNK_XMIT)
      seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_REST;
      pend_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      seen_q  <= seen_d;
    end
  end

  assign state_o   = state_q;
  assign arb_req_o = (state_q == ST_ARB);

  assert_no_arb_root_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REST && start && root_iso_i) |=> (state_q == ST_PFX && !arb_req_o));

  assert_link_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LINK && link_ctl_i == LNK_IDLE) |=> (state_q == ST_REST));

  assert_chain_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LINK && link_ctl_i == LNK_HOLD && seen_q) |=> (state_q == ST_GAP));

  assert_queue_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LINK && lreq_i) |=> pend_q);
endmodule

// File: rtl/phy_grant_ctrl.sv
module phy_grant_ctrl
  import phy_grant_pkg::*;
#(
  parameter int PFX_NORM = 4,
  parameter int PFX_EXT  = 16,
  parameter int GAP_LEN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lreq_i,
  input  logic       root_iso_i,
  input  logic       arb_won_i,
  output logic       arb_req_o,
  input  logic [1:0] link_ctl_i,
  output logic [1:0] ctl_o,
  output logic       ctl_oe_o,
  output logic [3:0] d_o,
  output logic       d_oe_o,
  output logic       prefix_o,
  output logic       data_on_o
);
  localparam int MAXL = (PFX_EXT > PFX_NORM) ?
                        ((PFX_EXT > GAP_LEN) ? PFX_EXT : GAP_LEN) :
                        ((PFX_NORM > GAP_LEN) ? PFX_NORM : GAP_LEN);
  localparam int CW = $clog2(MAXL + 1);

  logic          rst_n_s;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  state_t        state;

  pgc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  pgc_timer #(.W(CW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  pgc_fsm #(
    .PFX_NORM (PFX_NORM),
    .PFX_EXT  (PFX_EXT),
    .GAP_LEN  (GAP_LEN),
    .CW       (CW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .lreq_i     (lreq_i),
    .root_iso_i (root_iso_i),
    .arb_won_i  (arb_won_i),
    .link_ctl_i (link_ctl_i),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .state_o    (state),
    .arb_req_o  (arb_req_o)
  );

  // pin drivers
  always_comb begin
    ctl_oe_o  = (state != ST_LINK);
    d_oe_o    = ctl_oe_o;
    d_o       = 4'b0000;
    ctl_o     = (state == ST_GRANT) ? PHY_GRANT : PHY_IDLE;
    prefix_o  = (state == ST_PFX) || (state == ST_GAP) ||
                (state == ST_LINK && link_ctl_i == LNK_HOLD);
    data_on_o = (state == ST_LINK && link_ctl_i == LNK_XMIT);
  end

  assert_grant_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl_oe_o && ctl_o == PHY_GRANT) |=> (ctl_oe_o && ctl_o == PHY_IDLE));

  assert_release_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl_oe_o && ctl_o == PHY_GRANT) |=> ##1 (!ctl_oe_o && !d_oe_o));

  assert_d_zero_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl_oe_o |-> (d_oe_o && d_o == 4'b0000));

  assert_link_idle_ctl_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ctl_oe_o && link_ctl_i == LNK_IDLE) |=> (ctl_oe_o && ctl_o == PHY_IDLE));
endmodule

// File: tb/sim_phy_grant_ctrl.sv
module sim_phy_grant_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lreq = 1'b0, root_iso = 1'b0, arb_won = 1'b0;
  logic [1:0] link_ctl = 2'b00;
  logic       arb_req, ctl_oe, d_oe, prefix, data_on;
  logic [1:0] ctl;
  logic [3:0] d;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  phy_grant_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .lreq_i(lreq), .root_iso_i(root_iso),
    .arb_won_i(arb_won), .arb_req_o(arb_req), .link_ctl_i(link_ctl),
    .ctl_o(ctl), .ctl_oe_o(ctl_oe), .d_o(d), .d_oe_o(d_oe),
    .prefix_o(prefix), .data_on_o(data_on)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_test();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ctl_oe", ctl_oe, 1);
    chk("R1 ctl", ctl, 0);
    chk("R1 d_oe", d_oe, 1);
    chk("R1 d", d, 0);
    chk("R1 arb_req", arb_req, 0);
    chk("R1 prefix", prefix + data_on, 0);
  endtask

  // count prefix cycles until grant, then verify the grant shape (R3)
  task automatic count_to_grant(input string req, input int exp, input bit no_arb);
    int n = 0;
    int guard = 0;
    bit arb_seen = 0;
    while (!(ctl_oe && ctl == 2'b11) && guard < 100) begin
      if (prefix) n++;
      if (arb_req) arb_seen = 1;
      if (ctl_oe && d != 0) chk("R11 d zero", d, 0);
      guard++;
      @(negedge clk);
    end
    chk(req, n, exp);
    if (no_arb) chk("R9 no arb_req", arb_seen, 0);
    @(negedge clk);
    chk("R3 idle after grant", {ctl_oe, ctl}, 3'b100);
    chk("R11 d driven zero", {d_oe, d}, 5'b10000);
    @(negedge clk);
    chk("R3 release", {ctl_oe, d_oe}, 0);
  endtask

  task automatic arb_start();
    lreq = 1'b1;
    @(negedge clk);
    lreq = 1'b0;
    chk("R2 arb_req rises", arb_req, 1);
    @(negedge clk);
    chk("R2 arb_req held", arb_req, 1);
    @(negedge clk);
    arb_won = 1'b1;
    @(negedge clk);
    arb_won = 1'b0;
  endtask

  task automatic link_packet(input int holds, input int datas, input bit req_mid);
    for (int i = 0; i < holds; i++) begin
      link_ctl = 2'b01;
      #1;
      chk("R5 prefix on hold", prefix, 1);
      chk("R5 ctl released", ctl_oe, 0);
      @(negedge clk);
    end
    for (int i = 0; i < datas; i++) begin
      link_ctl = 2'b10;
      if (req_mid && i == 0) lreq = 1'b1;
      #1;
      chk("R6 data_on", data_on, 1);
      chk("R6 prefix off", prefix, 0);
      @(negedge clk);
      lreq = 1'b0;
    end
  endtask

  task automatic link_end();
    link_ctl = 2'b00;
    @(negedge clk);
    chk("R8 phy idle ctl", {ctl_oe, ctl}, 3'b100);
    chk("R8 no prefix", prefix, 0);
  endtask

  task automatic test_normal();
    arb_start();
    count_to_grant("R4 normal prefix length", 4, 0);
    link_packet(2, 3, 0);
    link_end();
    @(negedge clk);
    chk("R8 rest, no arb_req", arb_req, 0);
  endtask

  task automatic test_chain();
    arb_start();
    count_to_grant("R4 prefix before chain", 4, 0);
    link_packet(0, 2, 0);
    link_ctl = 2'b01;
    @(negedge clk);
    link_ctl = 2'b00;
    chk("R7 phy retakes ctl", {ctl_oe, ctl}, 3'b100);
    count_to_grant("R7 gap length", 4, 0);
    link_packet(1, 2, 0);
    link_end();
  endtask

  task automatic test_root();
    root_iso = 1'b1;
    lreq = 1'b1;
    @(negedge clk);
    lreq = 1'b0;
    root_iso = 1'b0;
    count_to_grant("R9 extended prefix length", 16, 1);
    link_packet(0, 2, 0);
    link_end();
  endtask

  task automatic test_queue();
    arb_start();
    count_to_grant("R4 prefix before queue", 4, 0);
    link_packet(0, 3, 1);
    link_end();
    @(negedge clk);
    chk("R10 queued request arbitrates", arb_req, 1);
    arb_won = 1'b1;
    @(negedge clk);
    arb_won = 1'b0;
    count_to_grant("R4 prefix queued", 4, 0);
    link_end();
    @(negedge clk);
    chk("R10 queue cleared", arb_req, 0);
  endtask

  initial begin
    fork
      begin
        reset_test();
        test_normal();
        test_chain();
        test_root();
        test_queue();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule